// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Majority Vote

This block turns the asynchronous CAN receive line into one resolved bit value per bit period. The line first passes through a two-stage synchronizer. A free-running divider turns the IO clock into time quanta of programmable length. A segment counter walks those quanta through the synchronization quantum, the propagation segment and the two phase segments. The counter marks the sample point where phase segment 1 ends.

At the sample point the block resolves the line level in one of two ways. In single mode it takes the synchronized line as it is. In triple mode it takes a 2-of-3 majority of the synchronized line two IO clocks before the sample point, one IO clock before it, and at it. Triple mode is forced off when the prescaler is zero, because the quantum is then a single IO clock.

The result is registered and comes with a one-cycle valid strobe. The frame layer drives a start-of-bit input to realign the quantum and segment counters to a bit boundary. Edge-driven resynchronization, frame decoding and error counting are left to the surrounding logic.

Top module: `can_bit_sampler`

## Requirements
- R1: While reset is asserted, and until the first sample after it, `sampledBit` is 1 (recessive) and `sampleValid` is 0.
- R2: A time quantum lasts `prescaler`+1 IO clocks, with `prescaler` 6 bits wide. The sample point is the last IO clock of quantum number 3+`propSeg`+`phase1Seg`, counted from 1 after start-of-bit. `sampleValid` is 1 in the IO clock that follows it.
- R3: `sampleValid` lasts exactly one IO clock. It recurs every (4+`propSeg`+`phase1Seg`+`phase2Seg`) quanta while `startOfBit` stays low.
- R4: In single mode (`tripleMode`=0), `sampledBit` equals the level that `rxAsync` held during the IO clock two cycles before the sample-point cycle. This is the line as seen through the two-stage synchronizer.
- R5: In triple mode with `prescaler`≠0, `sampledBit` is the 2-of-3 majority of the synchronized line at the sample-point cycle and the two cycles before it. These are the `rxAsync` levels 2, 3 and 4 cycles before the sample-point cycle.
- R6: When `prescaler` is 0, `tripleMode` has no effect and the bit is resolved as in R4.
- R7: A cycle with `startOfBit`=1 resets the divider and the segment counter. The first quantum begins on the next IO clock, no sample point falls in that cycle, and the pending bit timing is discarded.
- R8: `sampledBit` keeps its value between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IO clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxAsync | input | 1 | Asynchronous CAN receive line |
| startOfBit | input | 1 | Realigns quantum and segment counters |
| prescaler | input | 6 | Quantum length minus one, in IO clocks |
| propSeg | input | 4 | Propagation segment length minus one, in quanta |
| phase1Seg | input | 4 | Phase segment 1 length minus one, in quanta |
| phase2Seg | input | 4 | Phase segment 2 length minus one, in quanta |
| tripleMode | input | 1 | 1 selects three-sample majority |
| sampledBit | output | 1 | Resolved bit level |
| sampleValid | output | 1 | One-cycle strobe for a new `sampledBit` |

## Verification
After a start-of-bit in cycle -1, the sample point falls in cycle (3+prop+ph1)·(prescaler+1)−1. The valid strobe and the new bit appear one cycle later, and the second strobe follows one full bit period after the first. The line value that counts is the one driven two cycles before the sample-point cycle, plus the two before that in triple mode. The bench writes a 3-bit pattern into exactly those cycles and compares outputs only at the computed strobe cycles. It also counts strobes that fall anywhere else. It sweeps prescaler, segment lengths, mode and all eight patterns.

// File: rtl/can_samp_pkg.sv
package can_samp_pkg;

  typedef struct packed {
    logic samplePoint;
    logic useTriple;
  } ctrlStrobes_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_samp_ctrl.sv
module can_samp_ctrl
  import can_samp_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int SEG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startOfBit,
  input  logic [PRESC_W-1:0] prescaler,
  input  logic [SEG_W-1:0]   propSeg,
  input  logic [SEG_W-1:0]   phase1Seg,
  input  logic [SEG_W-1:0]   phase2Seg,
  input  logic               tripleMode,
  output ctrlStrobes_t       strobes
);

  localparam int CNT_W = SEG_W + 3;

  logic [PRESC_W-1:0] qCnt;
  logic [CNT_W-1:0]   segCnt;
  logic [CNT_W-1:0]   spIdx;
  logic [CNT_W-1:0]   lastIdx;
  logic               qTick;

  // Quantum index (0-based) whose end is the sample point, and last quantum.
  always_comb begin
    spIdx   = CNT_W'(2) + CNT_W'(propSeg) + CNT_W'(phase1Seg);
    lastIdx = spIdx + CNT_W'(1) + CNT_W'(phase2Seg);
  end

  assign qTick = (qCnt >= prescaler);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCnt   <= '0;
      segCnt <= '0;
    end else if (startOfBit) begin
      qCnt   <= '0;
      segCnt <= '0;
    end else if (qTick) begin
      qCnt   <= '0;
      segCnt <= (segCnt >= lastIdx) ? '0 : segCnt + CNT_W'(1);
    end else begin
      qCnt   <= qCnt + PRESC_W'(1);
    end
  end

  always_comb begin
    strobes.samplePoint = qTick && (segCnt == spIdx) && !startOfBit;
    strobes.useTriple   = tripleMode && (prescaler != '0);
  end

  AST_SOB_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    startOfBit |=> (qCnt == '0) && (segCnt == '0)); // R7

  AST_SOB_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    startOfBit |-> !strobes.samplePoint); // R7

endmodule

// File: rtl/can_samp_dp.sv
module can_samp_dp
  import can_samp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_DEPTH  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxAsync,
  input  ctrlStrobes_t strobes,
  output logic         syncLine,
  output logic         sampledBit,
  output logic         sampleValid
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [HIST_DEPTH-1:0]  hist;
  logic                   voted;

  // Synchronizer chain, reset to recessive.
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[0] <= 1'b1;
          else       syncReg[0] <= rxAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[i] <= 1'b1;
          else       syncReg[i] <= syncReg[i-1];
        end
      end
    end
  endgenerate

  assign syncLine = syncReg[SYNC_STAGES-1];

  // hist[0] is one IO clock old, hist[1] two IO clocks old.
  always_ff @(posedge clk) begin
    if (!rstN) hist <= '1;
    else       hist <= {hist[HIST_DEPTH-2:0], syncLine};
  end

  always_comb begin
    if (strobes.useTriple) voted = maj3(hist[1], hist[0], syncLine);
    else                   voted = syncLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampledBit  <= 1'b1;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.samplePoint;
      if (strobes.samplePoint) sampledBit <= voted;
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.samplePoint |=> $stable(sampledBit)); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R3

  AST_TRIPLE_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.samplePoint && strobes.useTriple && hist[1] == hist[0])
      |=> sampledBit == $past(hist[0])); // R5

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_samp_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int SEG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxAsync,
  input  logic               startOfBit,
  input  logic [PRESC_W-1:0] prescaler,
  input  logic [SEG_W-1:0]   propSeg,
  input  logic [SEG_W-1:0]   phase1Seg,
  input  logic [SEG_W-1:0]   phase2Seg,
  input  logic               tripleMode,
  output logic               sampledBit,
  output logic               sampleValid
);

  ctrlStrobes_t strobes;
  logic         syncLine;

  can_samp_ctrl #(.PRESC_W(PRESC_W), .SEG_W(SEG_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startOfBit (startOfBit),
    .prescaler  (prescaler),
    .propSeg    (propSeg),
    .phase1Seg  (phase1Seg),
    .phase2Seg  (phase2Seg),
    .tripleMode (tripleMode),
    .strobes    (strobes)
  );

  can_samp_dp #(.SYNC_STAGES(2), .HIST_DEPTH(2)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxAsync     (rxAsync),
    .strobes     (strobes),
    .syncLine    (syncLine),
    .sampledBit  (sampledBit),
    .sampleValid (sampleValid)
  );

  AST_FAST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.samplePoint && prescaler == '0) |=> sampledBit == $past(syncLine)); // R6

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.samplePoint |=> sampleValid); // R2

endmodule

// File: tb/can_bit_sampler_bench.sv
module can_bit_sampler_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxAsync;
  logic       startOfBit;
  logic [5:0] prescaler;
  logic [3:0] propSeg, phase1Seg, phase2Seg;
  logic       tripleMode;
  logic       sampledBit, sampleValid;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;

  always #10 clk = ~clk;  // 50 MHz

  can_bit_sampler u_can_bit_sampler (
    .clk(clk), .rstN(rstN), .rxAsync(rxAsync), .startOfBit(startOfBit),
    .prescaler(prescaler), .propSeg(propSeg), .phase1Seg(phase1Seg),
    .phase2Seg(phase2Seg), .tripleMode(tripleMode),
    .sampledBit(sampledBit), .sampleValid(sampleValid)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (presc=%0d prop=%0d ph1=%0d ph2=%0d trip=%0d)",
               req, act, exp, prescaler, propSeg, phase1Seg, phase2Seg, tripleMode);
    end
  endtask

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // One run: start-of-bit in cycle -1, pattern written into the sampled cycles.
  task automatic runCase(input int presc, input int prop, input int ph1,
                         input int ph2, input logic trip, input logic [2:0] pat);
    int q   = presc + 1;
    int c   = (3 + prop + ph1) * q - 1;       // sample-point cycle
    int per = (4 + prop + ph1 + ph2) * q;     // bit period in cycles
    int total = c + per + 3;
    int extra = 0;
    logic exp1, exp2, useTrip;
    logic rxPlan [0:1023];
    for (int j = 0; j < total; j++) rxPlan[j] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (c - 4 + k >= 0)       rxPlan[c - 4 + k]       = pat[k];
      if (c - 4 + k + per >= 0) rxPlan[c - 4 + k + per] = ~pat[k];
    end
    useTrip = trip && (presc != 0);
    exp1 = useTrip ? maj(pat[0], pat[1], pat[2]) : pat[2];
    exp2 = ~exp1;
    @(negedge clk);
    prescaler  = 6'(presc);
    propSeg    = 4'(prop);
    phase1Seg  = 4'(ph1);
    phase2Seg  = 4'(ph2);
    tripleMode = trip;
    startOfBit = 1'b1;
    rxAsync    = 1'b1;
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      startOfBit = 1'b0;
      if (j == c + 1) begin
        check("R2 valid at sample point+1", int'(sampleValid), 1);
        check(useTrip ? "R5 majority bit" : (trip ? "R6 single forced" : "R4 single bit"),
              int'(sampledBit), int'(exp1));
      end else if (j == c + 1 + per) begin
        check("R3 valid after one bit period", int'(sampleValid), 1);
        check(useTrip ? "R5 majority bit 2" : "R4 single bit 2", int'(sampledBit), int'(exp2));
      end else if (j == c + per) begin
        check("R8 bit held", int'(sampledBit), int'(exp1));
      end else if (sampleValid) begin
        extra++;
      end
      rxAsync = rxPlan[j];
    end
    check("R3/R7 no stray valid", extra, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=%0d expected<=190000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    int pl [4] = '{0, 1, 2, 5};
    rstN = 1'b0; rxAsync = 1'b0; startOfBit = 1'b0;
    prescaler = '0; propSeg = '0; phase1Seg = '0; phase2Seg = '0; tripleMode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset bit", int'(sampledBit), 1);
    check("R1 reset valid", int'(sampleValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bit after reset", int'(sampledBit), 1);
    check("R1 valid after reset", int'(sampleValid), 0);
    // R7: every run restarts mid-bit from the previous run's counter state.
    foreach (pl[i])
      for (int prop = 0; prop < 2; prop++)
        for (int ph1 = 0; ph1 < 2; ph1++)
          for (int ph2 = 0; ph2 < 2; ph2++)
            for (int trip = 0; trip < 2; trip++)
              for (int pat = 0; pat < 8; pat++)
                runCase(pl[i], prop, ph1, ph2, 1'(trip), 3'(pat));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule